// File: doc/BRIEF.md
# Two-Bank SDRAM Word Access Controller

This controller sits between a simple single-word request port and a two-bank SDRAM with 16-bit data. Each bank has 2,048 rows of 256 columns. After reset it runs the power-up sequence and programs the mode register. From then on it turns each accepted request into an activate command followed by a read or a write that carries auto-precharge. It also issues an auto-refresh on a fixed interval, so the host never has to keep track of refresh.

A request is a 20-bit word address with a write flag, 16-bit write data and two byte enables. The top address bit picks the bank, the next eleven bits pick the row and the low eight bits pick the column. Read data comes back with a single-cycle valid pulse. All command, address, mask and data outputs are registered. Every cycle that carries no command drives a no-operation on the command pins.

Top module: `sdram_word_ctrl`

## Requirements
- R1: After reset, CKE is high and only no-operation commands appear for at least INIT_CYCLES cycles. The next commands are, in order: a precharge with A10 high (all banks), two auto-refresh commands, and a mode register load with address value 0x030 (burst length 1, sequential order, latency 3). No activate appears before that load, and req_ready stays low until it.
- R2: The command pins {CS,RAS,CAS,WE} carry 0111 (no-operation) on every cycle without a command. The other codes are: activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode load 0000. CS never goes high.
- R3: For each request, activate drives bank req_addr[19] on A11 and row req_addr[18:8] on A10..A0. The following read or write drives the same bank on A11 and column req_addr[7:0] on A7..A0.
- R4: The read or write command comes exactly T_RCD cycles after the activate of the same request.
- R5: Every read and write carries A10 high (auto-precharge). The next activate comes no earlier than T_RP+1 cycles after a read, and no earlier than T_WR+T_RP cycles after a write.
- R6: An activate goes only to a bank that is closed and has finished precharging. A read or write goes only to an open bank.
- R7: A write drives req_wdata on the DQ outputs with the output enable high in that cycle only. Mask bit 0 covers DQ7..0 and mask bit 1 covers DQ15..8; a mask bit is high (lane not written) exactly when its byte enable is low.
- R8: The value on the DQ inputs CAS_LAT cycles after a read command is returned on rd_data. rd_valid is high for one cycle, CAS_LAT+1 cycles after the read command.
- R9: After initialisation, auto-refresh commands follow one another every REF_INTERVAL cycles, give or take the length of one access. A pending refresh is served before a waiting request, so refresh keeps its rate under back-to-back traffic.
- R10: Refresh and mode load are issued only while both banks are closed and precharged. No command follows a refresh by fewer than T_RFC cycles, or a mode load by fewer than T_MRD cycles.
- R11: req_ready is high only while the controller is idle with no refresh pending. Each accepted request produces exactly one activate, on the cycle after acceptance, and the accesses appear in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address {bank, row, column} |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| rd_data | output | 16 | Read data |
| rd_valid | output | 1 | Read data valid pulse |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 12 | Address bus, A11 = bank |
| sd_dq_out | output | 16 | Data driven to memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 16 | Data returned from memory |
| sd_dqm | output | 2 | Byte masks, bit 0 = DQ7..0 |

## Verification
The bench shortens INIT_CYCLES to 50 and REF_INTERVAL to 200 and keeps the 3-3-3 latencies and the default geometry. The short power-up wait brings the whole init sequence into the first few dozen cycles. The short refresh interval means a run of a few thousand cycles contains many refreshes. Some of them then collide with back-to-back requests, which tests the refresh priority and the interval bound. Addresses are drawn from a few rows and columns in both banks, so reads hit earlier byte-masked writes.

// File: rtl/sdram_word_pkg.sv
package sdram_word_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_PALL,
    ST_IREF,
    ST_MRS,
    ST_IDLE,
    ST_RW,
    ST_WAIT
  } seq_st_e;

endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ack,
  output logic pending
);
  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          tick;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    tick   = run && (cnt_q == '0);
    if (run) cnt_d = tick ? CW'(INTERVAL - 1) : cnt_q - 1'b1;
    if (ack) pend_d = 1'b0;
    if (tick) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CW'(INTERVAL - 1);
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int CL = 3,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic [CL-1:0] sh_q, sh_d;
  logic [DW-1:0] data_q;
  logic          valid_q;

  generate
    if (CL == 1) begin : g_cl1
      assign sh_d = issue;
    end else begin : g_cln
      assign sh_d = {sh_q[CL-2:0], issue};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      sh_q    <= sh_d;
      valid_q <= sh_q[CL-1];
      if (sh_q[CL-1]) data_q <= dq_in;
    end
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;
endmodule

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
  import sdram_word_pkg::*;
#(
  parameter int INIT_CYCLES = 20000,
  parameter int T_RCD       = 3,
  parameter int T_RP        = 3,
  parameter int T_RFC       = 7,
  parameter int T_WR        = 2,
  parameter int T_MRD       = 2,
  parameter int CAS_LAT     = 3,
  parameter int ROW_W       = 11,
  parameter int COL_W       = 8,
  parameter int DW          = 16,
  parameter int AP_BIT      = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W:0]   req_addr,
  input  logic [DW-1:0]          req_wdata,
  input  logic [DW/8-1:0]        req_be,
  input  logic                   ref_pend,
  output logic                   ref_ack,
  output logic                   ref_run,
  output sd_cmd_e                cmd_q,
  output logic [ROW_W:0]         addr_q,
  output logic [DW-1:0]          dq_q,
  output logic                   oe_q,
  output logic [DW/8-1:0]        dqm_q,
  output logic                   cke_q
);
  localparam int AW      = ROW_W + COL_W + 1;
  localparam int SA_W    = ROW_W + 1;
  localparam int BE_W    = DW / 8;
  localparam int ACC_MAX = T_WR + T_RP + T_RFC + T_RCD + T_MRD + CAS_LAT;
  localparam int CNT_MAX = (INIT_CYCLES > ACC_MAX) ? INIT_CYCLES : ACC_MAX;
  localparam int CW      = $clog2(CNT_MAX + 1);
  // a wait load of L places the next command L+2 cycles after this one
  localparam logic [CW-1:0] L_RP  = CW'(T_RP - 2);
  localparam logic [CW-1:0] L_RFC = CW'(T_RFC - 2);
  localparam logic [CW-1:0] L_MRD = CW'(T_MRD - 2);
  localparam logic [CW-1:0] L_RCD = CW'(T_RCD - 2);
  localparam logic [CW-1:0] L_RDA = CW'(T_RP - 1);
  localparam logic [CW-1:0] L_WRA = CW'(T_WR + T_RP - 2);
  localparam logic [SA_W-1:0] MODE_WORD = SA_W'(CAS_LAT << 4);

  seq_st_e          st_q, st_d, ret_q, ret_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             iref_q, iref_d, run_q, run_d;
  logic             lat_en;
  logic             lw_q;
  logic [AW-1:0]    la_q;
  logic [DW-1:0]    ld_q;
  logic [BE_W-1:0]  lb_q;
  sd_cmd_e          cmd_d;
  logic [SA_W-1:0]  addr_d;
  logic [DW-1:0]    dq_d;
  logic             oe_d;
  logic [BE_W-1:0]  dqm_d;

  always_comb begin
    st_d      = st_q;
    ret_d     = ret_q;
    cnt_d     = cnt_q;
    iref_d    = iref_q;
    run_d     = run_q;
    lat_en    = 1'b0;
    req_ready = 1'b0;
    ref_ack   = 1'b0;
    cmd_d     = CMD_NOP;
    addr_d    = '0;
    dq_d      = '0;
    oe_d      = 1'b0;
    dqm_d     = '0;
    unique case (st_q)
      ST_PWR: begin
        if (cnt_q == '0) st_d = ST_PALL;
        else cnt_d = cnt_q - 1'b1;
      end
      ST_PALL: begin
        cmd_d          = CMD_PRE;
        addr_d[AP_BIT] = 1'b1;
        cnt_d          = L_RP;
        ret_d          = ST_IREF;
        st_d           = ST_WAIT;
      end
      ST_IREF: begin
        cmd_d  = CMD_REF;
        cnt_d  = L_RFC;
        iref_d = 1'b1;
        ret_d  = iref_q ? ST_MRS : ST_IREF;
        st_d   = ST_WAIT;
      end
      ST_MRS: begin
        cmd_d  = CMD_MRS;
        addr_d = MODE_WORD;
        cnt_d  = L_MRD;
        run_d  = 1'b1;
        ret_d  = ST_IDLE;
        st_d   = ST_WAIT;
      end
      ST_IDLE: begin
        if (ref_pend) begin
          cmd_d   = CMD_REF;
          ref_ack = 1'b1;
          cnt_d   = L_RFC;
          ret_d   = ST_IDLE;
          st_d    = ST_WAIT;
        end else begin
          req_ready = 1'b1;
          if (req_valid) begin
            lat_en = 1'b1;
            cmd_d  = CMD_ACT;
            addr_d = {req_addr[AW-1], req_addr[AW-2 -: ROW_W]};
            cnt_d  = L_RCD;
            ret_d  = ST_RW;
            st_d   = ST_WAIT;
          end
        end
      end
      ST_RW: begin
        addr_d[SA_W-1]    = la_q[AW-1];
        addr_d[AP_BIT]    = 1'b1;
        addr_d[COL_W-1:0] = la_q[COL_W-1:0];
        if (lw_q) begin
          cmd_d = CMD_WR;
          oe_d  = 1'b1;
          dq_d  = ld_q;
          dqm_d = ~lb_q;
          cnt_d = L_WRA;
        end else begin
          cmd_d = CMD_RD;
          cnt_d = L_RDA;
        end
        ret_d = ST_IDLE;
        st_d  = ST_WAIT;
      end
      ST_WAIT: begin
        if (cnt_q == '0) st_d = ret_q;
        else cnt_d = cnt_q - 1'b1;
      end
      default: st_d = ST_PWR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PWR;
      ret_q  <= ST_PWR;
      cnt_q  <= CW'(INIT_CYCLES - 1);
      iref_q <= 1'b0;
      run_q  <= 1'b0;
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      dq_q   <= '0;
      oe_q   <= 1'b0;
      dqm_q  <= '0;
      cke_q  <= 1'b0;
      lw_q   <= 1'b0;
      la_q   <= '0;
      ld_q   <= '0;
      lb_q   <= '0;
    end else begin
      st_q   <= st_d;
      ret_q  <= ret_d;
      cnt_q  <= cnt_d;
      iref_q <= iref_d;
      run_q  <= run_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      dq_q   <= dq_d;
      oe_q   <= oe_d;
      dqm_q  <= dqm_d;
      cke_q  <= 1'b1;
      if (lat_en) begin
        lw_q <= req_write;
        la_q <= req_addr;
        ld_q <= req_wdata;
        lb_q <= req_be;
      end
    end
  end

  assign ref_run = run_q;
endmodule

// File: rtl/sdram_word_ctrl.sv
module sdram_word_ctrl
  import sdram_word_pkg::*;
#(
  parameter int INIT_CYCLES  = 20000,
  parameter int REF_INTERVAL = 1560,
  parameter int T_RCD        = 3,
  parameter int T_RP         = 3,
  parameter int T_RFC        = 7,
  parameter int T_WR         = 2,
  parameter int T_MRD        = 2,
  parameter int CAS_LAT      = 3,
  parameter int ROW_W        = 11,
  parameter int COL_W        = 8,
  parameter int DW           = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ROW_W+COL_W:0] req_addr,
  input  logic [DW-1:0]        req_wdata,
  input  logic [DW/8-1:0]      req_be,
  output logic [DW-1:0]        rd_data,
  output logic                 rd_valid,
  output logic                 sd_cke,
  output logic                 sd_cs_n,
  output logic                 sd_ras_n,
  output logic                 sd_cas_n,
  output logic                 sd_we_n,
  output logic [ROW_W:0]       sd_addr,
  output logic [DW-1:0]        sd_dq_out,
  output logic                 sd_dq_oe,
  input  logic [DW-1:0]        sd_dq_in,
  output logic [DW/8-1:0]      sd_dqm
);
  sd_cmd_e cmd_q;
  logic    ref_pend, ref_ack, ref_run;

  sdram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ref_run),
    .ack     (ref_ack),
    .pending (ref_pend)
  );

  sdram_seq_fsm #(
    .INIT_CYCLES (INIT_CYCLES),
    .T_RCD       (T_RCD),
    .T_RP        (T_RP),
    .T_RFC       (T_RFC),
    .T_WR        (T_WR),
    .T_MRD       (T_MRD),
    .CAS_LAT     (CAS_LAT),
    .ROW_W       (ROW_W),
    .COL_W       (COL_W),
    .DW          (DW),
    .AP_BIT      (10)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .ref_pend  (ref_pend),
    .ref_ack   (ref_ack),
    .ref_run   (ref_run),
    .cmd_q     (cmd_q),
    .addr_q    (sd_addr),
    .dq_q      (sd_dq_out),
    .oe_q      (sd_dq_oe),
    .dqm_q     (sd_dqm),
    .cke_q     (sd_cke)
  );

  sdram_rd_capture #(.CL(CAS_LAT), .DW(DW)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (cmd_q == CMD_RD),
    .dq_in    (sd_dq_in),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
endmodule

// File: rtl/sdram_word_ctrl_chk.sv
module sdram_word_ctrl_chk #(
  parameter int T_RCD  = 3,
  parameter int AW_SD  = 12,
  parameter int AP_BIT = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rd_valid,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [AW_SD-1:0] sd_addr,
  input logic             sd_dq_oe
);
  logic [3:0] cmd;
  logic [7:0] since_act;
  logic       is_rw;

  assign cmd   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_rw = (cmd == 4'b0101) || (cmd == 4'b0100);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_act <= '0;
    else if (cmd == 4'b0011) since_act <= 8'd1;
    else if (since_act != 8'hFF) since_act <= since_act + 8'd1;
  end

  a_r2_never_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cs_n);

  a_r11_accept_then_act: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd == 4'b0011));

  a_r4_rcd_exact: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> (since_act == 8'(T_RCD)));

  a_r5_auto_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> sd_addr[AP_BIT]);

  a_r7_oe_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe == (cmd == 4'b0100));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

bind sdram_word_ctrl sdram_word_ctrl_chk #(
  .T_RCD (T_RCD),
  .AW_SD (ROW_W + 1),
  .AP_BIT(10)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_addr   (sd_addr),
  .sd_dq_oe  (sd_dq_oe)
);

// File: tb/sdram_word_ctrl_tb_top.sv
module sdram_word_ctrl_tb_top;
  localparam int INIT = 50, RI = 200, T_RCD = 3, T_RP = 3, T_RFC = 7;
  localparam int T_WR = 2, T_MRD = 2, CL = 3, SLACK = 16;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
    C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rd_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [15:0] rd_data, sd_dq_out, sd_dq_in;
  logic [11:0] sd_addr;
  logic [1:0]  sd_dqm;

  always #4 clk = ~clk;

  sdram_word_ctrl #(.INIT_CYCLES(INIT), .REF_INTERVAL(RI), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RFC(T_RFC), .T_WR(T_WR), .T_MRD(T_MRD), .CAS_LAT(CL)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_data(rd_data), .rd_valid(rd_valid), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in), .sd_dqm(sd_dqm));

  int n_chk = 0, n_err = 0;
  task automatic chk(input bit ok, input string r, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", r, what, act, exp);
    end
  endtask

  typedef struct { bit wr; logic [19:0] a; logic [15:0] d; logic [1:0] be; logic [15:0] rexp; } req_t;
  typedef struct { int c; logic [15:0] d; } rdx_t;
  req_t rq[$];
  rdx_t rdq[$];
  logic [15:0] ref_mem [int];
  logic [15:0] pin_mem [int];

  // memory model state
  bit running = 0;
  int cyc = 0, init_step = 0, last_ref = 0, n_ref = 0, mrs_cyc = 0;
  bit open_b [2];
  int rdy_b [2];
  logic [10:0] row_b [2];
  int act_c [2];
  int glob_rdy = 0;
  logic [15:0] pd [0:CL];
  bit pv [0:CL];
  assign sd_dq_in = pv[CL] ? pd[CL] : 16'hDEAD;

  function automatic logic [15:0] merge(logic [15:0] old, logic [15:0] nw, logic [1:0] en);
    merge = old;
    if (en[0]) merge[7:0] = nw[7:0];
    if (en[1]) merge[15:8] = nw[15:8];
  endfunction

  always @(negedge clk) begin
    if (running) begin
      logic [3:0] c;
      logic [15:0] rdat;
      bit rd_now;
      int b;
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      b = int'(sd_addr[11]);
      rd_now = 0;
      rdat = '0;
      if (cyc >= 1) chk(sd_cke == 1'b1, "R1", "cke high", sd_cke, 1);
      chk(sd_dq_oe == (c == C_WR), "R7", "output enable only on write", sd_dq_oe, c == C_WR);
      if (init_step < 4 && c != C_NOP) begin
        case (init_step)
          0: begin
            chk(c == C_PRE && sd_addr[10], "R1", "first command precharge-all", c, C_PRE);
            chk(cyc >= INIT && cyc <= INIT + 4, "R1", "power-up wait", cyc, INIT);
          end
          1, 2: chk(c == C_REF, "R1", "init refresh", c, C_REF);
          default: begin
            chk(c == C_MRS, "R1", "mode load", c, C_MRS);
            chk(sd_addr == 12'h030, "R1", "mode word", sd_addr, 12'h030);
          end
        endcase
        init_step++;
      end
      case (c)
        C_NOP: ;
        C_PRE: begin
          chk(sd_addr[10], "R1", "precharge targets all banks", sd_addr, 12'h400);
          for (int i = 0; i < 2; i++) begin open_b[i] = 0; rdy_b[i] = cyc + T_RP; end
        end
        C_REF: begin
          chk(!open_b[0] && !open_b[1] && cyc >= rdy_b[0] && cyc >= rdy_b[1] && cyc >= glob_rdy,
              "R10", "refresh with banks closed", {open_b[1], open_b[0]}, 0);
          if (init_step >= 4 && mrs_cyc > 0) begin
            chk(cyc - last_ref <= RI + SLACK && cyc - last_ref >= RI - SLACK, "R9",
                "refresh spacing", cyc - last_ref, RI);
            n_ref++;
          end
          last_ref = cyc;
          glob_rdy = cyc + T_RFC;
        end
        C_MRS: begin
          chk(!open_b[0] && !open_b[1] && cyc >= glob_rdy && cyc >= rdy_b[0],
              "R10", "mode load with banks closed", {open_b[1], open_b[0]}, 0);
          mrs_cyc = cyc;
          last_ref = cyc;
          glob_rdy = cyc + T_MRD;
        end
        C_ACT: begin
          chk(init_step >= 4, "R1", "activate after init", init_step, 4);
          chk(!open_b[b] && cyc >= rdy_b[b] && cyc >= glob_rdy, "R6",
              "activate to precharged bank", cyc, rdy_b[b]);
          chk(cyc >= rdy_b[b], "R5", "precharge recovery before activate", cyc, rdy_b[b]);
          if (rq.size() == 0) chk(0, "R11", "activate without request", 1, 0);
          else begin
            chk(sd_addr[11] == rq[0].a[19], "R3", "activate bank", sd_addr[11], rq[0].a[19]);
            chk(sd_addr[10:0] == rq[0].a[18:8], "R3", "activate row", sd_addr[10:0], rq[0].a[18:8]);
          end
          open_b[b] = 1; row_b[b] = sd_addr[10:0]; act_c[b] = cyc;
        end
        C_RD, C_WR: begin
          chk(open_b[b], "R6", "access to open bank", open_b[b], 1);
          chk(cyc - act_c[b] == T_RCD, "R4", "activate-to-access delay", cyc - act_c[b], T_RCD);
          chk(sd_addr[10], "R5", "auto-precharge flag", sd_addr[10], 1);
          if (rq.size() == 0) chk(0, "R11", "access without request", 1, 0);
          else begin
            req_t r;
            int key;
            r = rq.pop_front();
            key = int'({sd_addr[11], row_b[b], sd_addr[7:0]});
            chk(sd_addr[11] == r.a[19], "R3", "access bank", sd_addr[11], r.a[19]);
            chk(sd_addr[7:0] == r.a[7:0], "R3", "column", sd_addr[7:0], r.a[7:0]);
            chk((c == C_WR) == r.wr, "R11", "access order/type", c, r.wr ? C_WR : C_RD);
            if (c == C_WR) begin
              chk(sd_dq_out == r.d, "R7", "write data", sd_dq_out, r.d);
              chk(sd_dqm == ~r.be, "R7", "byte masks", sd_dqm, ~r.be);
              pin_mem[key] = merge(pin_mem.exists(key) ? pin_mem[key] : 16'h0, sd_dq_out, ~sd_dqm);
              rdy_b[b] = cyc + T_WR + T_RP;
            end else begin
              rd_now = 1;
              rdat = pin_mem.exists(key) ? pin_mem[key] : 16'h0;
              rdq.push_back('{c: cyc + CL + 1, d: r.rexp});
              rdy_b[b] = cyc + T_RP + 1;
            end
          end
          open_b[b] = 0;
        end
        default: chk(0, "R2", "unknown command code", c, C_NOP);
      endcase
      // read-back scoreboard
      if (rdq.size() > 0 && rdq[0].c == cyc) begin
        chk(rd_valid, "R8", "read valid timing", rd_valid, 1);
        chk(rd_data == rdq[0].d, "R8", "read data", rd_data, rdq[0].d);
        void'(rdq.pop_front());
      end else if (rd_valid) chk(0, "R8", "spurious read valid", 1, 0);
      // data pipe toward the controller
      for (int i = CL; i > 0; i--) begin pd[i] = pd[i-1]; pv[i] = pv[i-1]; end
      pd[0] = rdat; pv[0] = rd_now;
      cyc++;
    end
  end

  task automatic send(input bit wr, input logic [19:0] a, input logic [15:0] d,
                      input logic [1:0] be, input int gap);
    int key;
    req_t r;
    repeat (gap) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    key = int'(a);
    r.wr = wr; r.a = a; r.d = d; r.be = be;
    r.rexp = ref_mem.exists(key) ? ref_mem[key] : 16'h0;
    if (wr) ref_mem[key] = merge(r.rexp, d, be);
    rq.push_back(r);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R11", "ready low after acceptance", req_ready, 0);
  endtask

  function automatic logic [19:0] rnd_addr();
    logic [10:0] row;
    case ($urandom % 4)
      0: row = 11'h000;
      1: row = 11'h7FF;
      2: row = 11'h001;
      default: row = 11'($urandom);
    endcase
    rnd_addr = {1'($urandom), row, 8'($urandom % 6)};
  endfunction

  initial begin
    int unused;
    unused = $urandom(32'h51D7);
    for (int i = 0; i <= CL; i++) begin pd[i] = '0; pv[i] = 0; end
    open_b[0] = 0; open_b[1] = 0; rdy_b[0] = 0; rdy_b[1] = 0;
    repeat (4) @(negedge clk);
    chk(!req_ready, "R1", "ready low in reset", req_ready, 0);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R2", "nop in reset",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    chk(!rd_valid && !sd_dq_oe, "R8", "no valid/oe in reset", {rd_valid, sd_dq_oe}, 0);
    rst_n = 1; running = 1;
    // ready must stay low until the mode load has been seen
    while (init_step < 4) begin
      @(negedge clk);
      if (init_step < 4) chk(!req_ready, "R1", "ready low during init", req_ready, 0);
    end
    // directed: extremes of the address space and byte lanes
    send(1, 20'hFFFFF, 16'hA5C3, 2'b11, 0);
    send(1, 20'h00000, 16'h1234, 2'b11, 0);
    send(0, 20'hFFFFF, 16'h0, 2'b00, 2);
    send(0, 20'h00000, 16'h0, 2'b00, 0);
    send(1, 20'h00000, 16'hEE77, 2'b01, 0);   // low lane only (R7)
    send(1, 20'h00000, 16'h99BB, 2'b10, 0);   // high lane only (R7)
    send(0, 20'h00000, 16'h0, 2'b00, 0);
    send(1, 20'h80001, 16'hCAFE, 2'b00, 0);   // fully masked write
    send(0, 20'h80001, 16'h0, 2'b00, 0);
    // same bank back-to-back, then alternating banks (R5, R6)
    for (int i = 0; i < 8; i++) send(i % 2, {1'b0, 11'h003, 8'(i / 2)}, 16'(i * 16'h1111), 2'b11, 0);
    for (int i = 0; i < 8; i++) send(0, {1'(i), 11'h003, 8'(i / 2)}, 16'h0, 2'b00, 0);
    // back-to-back burst spanning several refresh intervals (R9)
    for (int i = 0; i < 120; i++) send(1'($urandom), rnd_addr(), 16'($urandom), 2'($urandom), 0);
    // random mix with gaps
    for (int i = 0; i < 250; i++)
      send(1'($urandom), rnd_addr(), 16'($urandom), 2'($urandom), int'($urandom % 5));
    repeat (40) @(negedge clk);
    chk(rq.size() == 0, "R11", "all requests issued", rq.size(), 0);
    chk(rdq.size() == 0, "R8", "all reads returned", rdq.size(), 0);
    chk(n_ref >= (cyc - mrs_cyc) / (RI + SLACK), "R9", "refresh count", n_ref,
        (cyc - mrs_cyc) / (RI + SLACK));
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule